// File: doc/BRIEF.md
# Power Management Event and System Control Interrupt Controller

This block maps a small power-management register set into an I/O address window and turns hardware wake and power events into one level-sensitive system control interrupt (SCI). It holds an event status register, an event enable register, a control register and a readout of a free-running timer. Four event sources set sticky status bits: timer rollover, power button, global-lock release and real-time-clock alarm. Software clears a status bit by writing a one to it. The SCI line is high while any enabled source is pending, or while the external general-purpose event line is high.

A separate command port takes byte-wide power-management commands. One command code turns the SCI-enable control bit on and another turns it off. If a configuration bit allows it, every command also sends a one-cycle pulse on the system management interrupt (SMI) output. Byte-wide configuration writes set the base and enable of the I/O window and the SMI permission.

Top module: `pm_sci_ctrl`

## Requirements
- R1: After reset every register reads zero, `sci_out` and `smi_out` are low, the I/O window is closed and SMI generation is off. SMI generation stays off after a later reset until it is configured again.
- R2: The I/O window is decoded only while bit 0 of configuration byte 0x80 is 1. The window is 64 bytes long. Its base is {byte 0x41, byte 0x40} with the low six bits forced to zero. Outside the window, or while the window is closed, reads return 0 and writes have no effect.
- R3: Inside the window the registers sit at these offsets: 0x00 event status, 0x02 event enable, 0x04 control, 0x08 timer. Read data is combinational from `io_addr`. Any other offset reads 0, and a write to it changes no register.
- R4: Event status bits 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC) are write-one-to-clear. Writing a 0 leaves a bit unchanged. All other status bits always read 0.
- R5: `sci_out` is high, in the same cycle, exactly when (status AND enable AND 0x0521) is nonzero or `gpe_in` is high.
- R6: The timer advances by one every clock cycle. It reads as a TMR_W-bit value, zero-extended. When its top bit toggles, status bit 0 is set.
- R7: A high cycle on `pwrbtn_evt`, `gbl_evt` or `rtc_evt` sets status bit 8, 5 or 10 respectively.
- R8: A command write with code 0xF1 sets control bit 0. Code 0xF0 clears it. Any other code leaves the control register unchanged.
- R9: `smi_out` is high for exactly the one cycle after any command write, and only when bit 1 of configuration byte 0x5B is set.
- R10: When a hardware event and a write-one-to-clear of the same status bit fall in the same cycle, the bit ends up set. When a command and an I/O write of the control register fall in the same cycle, the command decides bit 0 and the I/O write supplies the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | DATA_W | Combinational I/O read data |
| apm_wr | input | 1 | Command port write strobe |
| apm_cmd | input | 8 | Command code |
| pwrbtn_evt | input | 1 | Power-button event, one cycle |
| gbl_evt | input | 1 | Global-lock release event, one cycle |
| rtc_evt | input | 1 | RTC alarm event, one cycle |
| gpe_in | input | 1 | External general-purpose event level |
| sci_out | output | 1 | System control interrupt level |
| smi_out | output | 1 | System management interrupt pulse |

## Verification
Two pairs of functions can land on the same clock edge. A status bit can receive a hardware set and a software write-one-to-clear together, and the control register can receive a command and an I/O write together. The bench polls the timer readout until it shows the value just before the top bit toggles. In that same cycle it issues a clear of timer status, and then it judges that the bit survived. In a separate cycle it drives a command write and a control register write together, and then it checks that bit 0 follows the command while the upper bits follow the write data.

// File: rtl/pmsci_pkg.sv
package pmsci_pkg;
  localparam int REG_W  = 16;
  localparam int WIN_LG = 6;

  localparam logic [WIN_LG-1:0] OFF_STS = 6'h00;
  localparam logic [WIN_LG-1:0] OFF_EN  = 6'h02;
  localparam logic [WIN_LG-1:0] OFF_CTL = 6'h04;
  localparam logic [WIN_LG-1:0] OFF_TMR = 6'h08;

  localparam int BIT_TMR = 0;
  localparam int BIT_GBL = 5;
  localparam int BIT_PWR = 8;
  localparam int BIT_RTC = 10;
  localparam logic [REG_W-1:0] SRC_MASK = 16'h0521;

  localparam logic [7:0] CMD_ON  = 8'hF1;
  localparam logic [7:0] CMD_OFF = 8'hF0;

  localparam logic [7:0] CFG_BASE_LO = 8'h40;
  localparam logic [7:0] CFG_BASE_HI = 8'h41;
  localparam logic [7:0] CFG_SMI     = 8'h5B;
  localparam logic [7:0] CFG_WIN     = 8'h80;

  // pending interrupt level
  function automatic logic sci_level(input logic [REG_W-1:0] sts,
                                     input logic [REG_W-1:0] en,
                                     input logic gpe);
    return (|(sts & en & SRC_MASK)) | gpe;
  endfunction

  // clear-on-one, with hardware sets taking priority
  function automatic logic [REG_W-1:0] w1c_next(input logic [REG_W-1:0] cur,
                                                input logic [REG_W-1:0] clr,
                                                input logic [REG_W-1:0] set);
    return ((cur & ~clr) | set) & SRC_MASK;
  endfunction
endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs #(
  parameter int BASE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic              win_en,
  output logic [BASE_W-1:0] base_hi,
  output logic              smi_en
);
  import pmsci_pkg::*;
  localparam int LO_KEEP = BASE_W - 8;

  logic [7:0]         hi_q;
  logic [LO_KEEP-1:0] lo_q;
  logic               win_q, smi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      win_q <= 1'b0;
      smi_q <= 1'b0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        CFG_BASE_LO: lo_q  <= cfg_wdata[7 -: LO_KEEP];
        CFG_BASE_HI: hi_q  <= cfg_wdata;
        CFG_WIN:     win_q <= cfg_wdata[0];
        CFG_SMI:     smi_q <= cfg_wdata[1];
        default: ;
      endcase
    end
  end

  assign win_en  = win_q;
  assign base_hi = {hi_q, lo_q};
  assign smi_en  = smi_q;
endmodule

// File: rtl/pm_win_decode.sv
module pm_win_decode #(
  parameter int ADDR_W = 16,
  parameter int WIN_LG = 6
) (
  input  logic                     win_en,
  input  logic [ADDR_W-WIN_LG-1:0] base_hi,
  input  logic [ADDR_W-1:0]        addr,
  output logic                     hit,
  output logic [WIN_LG-1:0]        off
);
  assign hit = win_en && (addr[ADDR_W-1:WIN_LG] == base_hi);
  assign off = addr[WIN_LG-1:0];
endmodule

// File: rtl/pm_free_timer.sv
module pm_free_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [TMR_W-1:0] count,
  output logic             wrap_evt
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  // top bit toggles on the coming edge
  assign wrap_evt = &cnt_q[TMR_W-2:0];
  assign count    = cnt_q;
endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs
  import pmsci_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sts_wr,
  input  logic             en_wr,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             apm_wr,
  input  logic [7:0]       apm_cmd,
  input  logic             tmr_evt,
  input  logic             gbl_evt,
  input  logic             pwr_evt,
  input  logic             rtc_evt,
  output logic [REG_W-1:0] sts,
  output logic [REG_W-1:0] en,
  output logic [REG_W-1:0] ctl
);
  logic [REG_W-1:0] set_vec, clr_vec, ctl_nxt;

  always_comb begin
    set_vec          = '0;
    set_vec[BIT_TMR] = tmr_evt;
    set_vec[BIT_GBL] = gbl_evt;
    set_vec[BIT_PWR] = pwr_evt;
    set_vec[BIT_RTC] = rtc_evt;
    clr_vec          = sts_wr ? wdata : '0;
  end

  always_comb begin
    ctl_nxt = ctl_wr ? wdata : ctl;
    if (apm_wr && apm_cmd == CMD_ON)  ctl_nxt[0] = 1'b1;
    if (apm_wr && apm_cmd == CMD_OFF) ctl_nxt[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
      en  <= '0;
      ctl <= '0;
    end else begin
      sts <= w1c_next(sts, clr_vec, set_vec);
      if (en_wr) en <= wdata;
      ctl <= ctl_nxt;
    end
  end
endmodule

// File: rtl/pm_sci_ctrl.sv
module pm_sci_ctrl
  import pmsci_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TMR_W  = 24,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [REG_W-1:0]  io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              apm_wr,
  input  logic [7:0]        apm_cmd,
  input  logic              pwrbtn_evt,
  input  logic              gbl_evt,
  input  logic              rtc_evt,
  input  logic              gpe_in,
  output logic              sci_out,
  output logic              smi_out
);
  localparam int BASE_W = ADDR_W - WIN_LG;

  logic              win_en, smi_en, io_hit, tmr_wrap;
  logic [BASE_W-1:0] base_hi;
  logic [WIN_LG-1:0] io_off;
  logic [TMR_W-1:0]  tmr_cnt;
  logic [REG_W-1:0]  sts_q, en_q, ctl_q;
  logic              sts_wr, en_wr, ctl_wr, smi_q;

  pm_cfg_regs #(.BASE_W(BASE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .win_en(win_en), .base_hi(base_hi), .smi_en(smi_en)
  );

  pm_win_decode #(.ADDR_W(ADDR_W), .WIN_LG(WIN_LG)) u_dec (
    .win_en(win_en), .base_hi(base_hi), .addr(io_addr), .hit(io_hit), .off(io_off)
  );

  pm_free_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .count(tmr_cnt), .wrap_evt(tmr_wrap)
  );

  assign sts_wr = io_wr && io_hit && (io_off == OFF_STS);
  assign en_wr  = io_wr && io_hit && (io_off == OFF_EN);
  assign ctl_wr = io_wr && io_hit && (io_off == OFF_CTL);

  pm_event_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sts_wr(sts_wr), .en_wr(en_wr), .ctl_wr(ctl_wr),
    .wdata(io_wdata), .apm_wr(apm_wr), .apm_cmd(apm_cmd), .tmr_evt(tmr_wrap),
    .gbl_evt(gbl_evt), .pwr_evt(pwrbtn_evt), .rtc_evt(rtc_evt),
    .sts(sts_q), .en(en_q), .ctl(ctl_q)
  );

  always_comb begin
    io_rdata = '0;
    if (io_hit) begin
      case (io_off)
        OFF_STS: io_rdata[REG_W-1:0] = sts_q;
        OFF_EN:  io_rdata[REG_W-1:0] = en_q;
        OFF_CTL: io_rdata[REG_W-1:0] = ctl_q;
        OFF_TMR: io_rdata[TMR_W-1:0] = tmr_cnt;
        default: io_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smi_q <= 1'b0;
    else        smi_q <= apm_wr && smi_en;
  end

  assign smi_out = smi_q;
  assign sci_out = sci_level(sts_q, en_q, gpe_in);
endmodule

// File: rtl/pm_sci_ctrl_chk.sv
module pm_sci_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        gpe_in,
  input logic        sci_out,
  input logic        apm_wr,
  input logic [7:0]  apm_cmd,
  input logic        smi_out,
  input logic [15:0] ctl_q,
  input logic [15:0] sts_q,
  input logic [15:0] io_wdata,
  input logic        sts_wr,
  input logic        tmr_wrap,
  input logic        pwrbtn_evt,
  input logic        win_en,
  input logic        io_hit
);
  assert_gpe_drives_sci_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gpe_in |-> sci_out);

  assert_cmd_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && apm_cmd == 8'hF1) |=> ctl_q[0]);

  assert_cmd_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (apm_wr && apm_cmd == 8'hF0) |=> !ctl_q[0]);

  assert_smi_after_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    smi_out |-> $past(apm_wr));

  assert_tmr_sets_sts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap |=> sts_q[0]);

  assert_pwr_sets_sts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwrbtn_evt |=> sts_q[8]);

  assert_closed_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> !io_hit);

  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_wrap && sts_wr && io_wdata[0]) |=> sts_q[0]);
endmodule

bind pm_sci_ctrl pm_sci_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gpe_in(gpe_in), .sci_out(sci_out),
  .apm_wr(apm_wr), .apm_cmd(apm_cmd), .smi_out(smi_out), .ctl_q(ctl_q),
  .sts_q(sts_q), .io_wdata(io_wdata), .sts_wr(sts_wr), .tmr_wrap(tmr_wrap),
  .pwrbtn_evt(pwrbtn_evt), .win_en(win_en), .io_hit(io_hit)
);

// File: tb/tb_pm_sci_ctrl.sv
module tb_pm_sci_ctrl;
  localparam int TW = 8;
  localparam logic [15:0] BASE = 16'hB000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_wr = 1'b0, io_wr = 1'b0, apm_wr = 1'b0;
  logic [7:0]  cfg_addr = '0, cfg_wdata = '0, apm_cmd = '0;
  logic [15:0] io_addr = '0, io_wdata = '0;
  logic [31:0] io_rdata;
  logic        pwrbtn_evt = 1'b0, gbl_evt = 1'b0, rtc_evt = 1'b0, gpe_in = 1'b0;
  logic        sci_out, smi_out;
  int          n_chk = 0, n_fail = 0;

  pm_sci_ctrl #(.DATA_W(32), .TMR_W(TW), .ADDR_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .apm_wr(apm_wr), .apm_cmd(apm_cmd),
    .pwrbtn_evt(pwrbtn_evt), .gbl_evt(gbl_evt), .rtc_evt(rtc_evt),
    .gpe_in(gpe_in), .sci_out(sci_out), .smi_out(smi_out)
  );

  always #4 clk = ~clk;

  // {write offset (FF = none), write data, read offset, expected}
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {8'h02, 16'h0521, 8'h02, 16'h0521},
    {8'h04, 16'h1234, 8'h04, 16'h1234},
    {8'h06, 16'hFFFF, 8'h06, 16'h0000},
    {8'hFF, 16'h0000, 8'h02, 16'h0521},
    {8'h0C, 16'hAAAA, 8'h0C, 16'h0000},
    {8'hFF, 16'h0000, 8'h04, 16'h1234},
    {8'h02, 16'h0000, 8'h02, 16'h0000},
    {8'h04, 16'h0001, 8'h04, 16'h0001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [15:0] d);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [31:0] v);
    io_addr = a;
    #1;
    v = io_rdata;
  endtask

  task automatic apm(input logic [7:0] c);
    apm_wr = 1'b1; apm_cmd = c;
    @(negedge clk);
    apm_wr = 1'b0;
  endtask

  task automatic open_window();
    cfg_write(8'h40, 8'h05);
    cfg_write(8'h41, 8'hB0);
    cfg_write(8'h80, 8'h01);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, t0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sci", {31'b0, sci_out}, 0);
    check("R1 smi", {31'b0, smi_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 closed window ignores writes
    cfg_write(8'h40, 8'h05);
    cfg_write(8'h41, 8'hB0);
    io_write(BASE + 16'h2, 16'h0100);
    io_read(BASE + 16'h2, v);
    check("R2 closed read", v, 0);
    cfg_write(8'h80, 8'h01);
    io_read(BASE + 16'h2, v);
    check("R2 closed write ignored", v, 0);
    io_read(BASE + 16'h0, v);
    check("R1 status zero", v, 0);
    io_read(BASE + 16'h4, v);
    check("R1 control zero", v, 0);

    // R3 vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][47:40] != 8'hFF) io_write(BASE + {8'h0, VEC[i][47:40]}, VEC[i][39:24]);
      io_read(BASE + {8'h0, VEC[i][23:16]}, v);
      check($sformatf("R3 vec %0d", i), v, {16'h0, VEC[i][15:0]});
    end

    // R2 window bound and base mask
    io_read(BASE + 16'h44, v);
    check("R2 beyond window", v, 0);
    io_read(BASE + 16'h3F, v);
    check("R2 last byte in window", v, 0);

    // R7 events set bits
    io_write(BASE + 16'h2, 16'h0000);
    pwrbtn_evt = 1'b1; @(negedge clk); pwrbtn_evt = 1'b0;
    io_read(BASE, v);
    check("R7 power button", v & 32'h0520, 32'h0100);
    check("R5 masked sci", {31'b0, sci_out}, 0);
    io_write(BASE + 16'h2, 16'h0100);
    check("R5 enabled sci", {31'b0, sci_out}, 1);
    io_write(BASE, 16'h0000);
    io_read(BASE, v);
    check("R4 write zero keeps", v & 32'h0100, 32'h0100);
    io_write(BASE, 16'h0100);
    io_read(BASE, v);
    check("R4 w1c clears", v & 32'h0100, 0);
    check("R5 sci after clear", {31'b0, sci_out}, 0);
    gbl_evt = 1'b1; rtc_evt = 1'b1; @(negedge clk); gbl_evt = 1'b0; rtc_evt = 1'b0;
    io_read(BASE, v);
    check("R7 gbl rtc", v & 32'h0520, 32'h0420);
    io_write(BASE, 16'hFFFF);
    io_read(BASE, v);
    check("R4 unused bits zero", v & 32'hFADE, 0);
    io_write(BASE + 16'h2, 16'h0000);
    gpe_in = 1'b1; #1;
    check("R5 gpe", {31'b0, sci_out}, 1);
    gpe_in = 1'b0; #1;
    check("R5 gpe low", {31'b0, sci_out}, 0);

    // R6 timer advance
    io_read(BASE + 16'h8, t0);
    repeat (5) @(negedge clk);
    io_read(BASE + 16'h8, v);
    check("R6 timer step", (v - t0) & 32'hFF, 5);
    check("R6 zero extend", v & 32'hFFFFFF00, 0);

    // R10 set beats clear on the same edge
    io_read(BASE + 16'h8, v);
    while (v[TW-2:0] != 7'h7F) begin
      @(negedge clk);
      io_read(BASE + 16'h8, v);
    end
    io_write(BASE, 16'h0001);
    io_read(BASE, v);
    check("R10 set wins", v & 1, 1);
    io_write(BASE, 16'h0001);
    io_read(BASE, v);
    check("R4 timer bit cleared", v & 1, 0);
    repeat (130) @(negedge clk);
    io_read(BASE, v);
    check("R6 rollover sets", v & 1, 1);
    io_write(BASE + 16'h2, 16'h0001);
    check("R5 timer sci", {31'b0, sci_out}, 1);
    io_write(BASE + 16'h2, 16'h0000);

    // R8 commands
    apm(8'hF0);
    io_read(BASE + 16'h4, v);
    check("R8 off", v, 0);
    check("R9 no smi when off", {31'b0, smi_out}, 0);
    apm(8'hF1);
    io_read(BASE + 16'h4, v);
    check("R8 on", v, 1);
    apm(8'h55);
    io_read(BASE + 16'h4, v);
    check("R8 other code", v, 1);

    // R10 command with control write
    apm_wr = 1'b1; apm_cmd = 8'hF1;
    io_write(BASE + 16'h4, 16'hA5A4);
    apm_wr = 1'b0;
    io_read(BASE + 16'h4, v);
    check("R10 cmd and write", v, 32'hA5A5);

    // R9 SMI pulse
    cfg_write(8'h5B, 8'h02);
    apm(8'h12);
    check("R9 smi pulse", {31'b0, smi_out}, 1);
    @(negedge clk);
    check("R9 smi one cycle", {31'b0, smi_out}, 0);

    // R1 reset clears SMI permission
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    open_window();
    apm(8'hF1);
    check("R1 smi off after reset", {31'b0, smi_out}, 0);
    io_read(BASE + 16'h4, v);
    check("R8 on after reset", v, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule